// File: doc/BRIEF.md
# Fractional-N Feedback Divider

This block divides a fast oscillator clock by a programmable ratio and emits one single-cycle feedback pulse per output period. With fractional operation off, every period lasts exactly the integer factor in oscillator cycles. With fractional operation on, a 17-bit phase accumulator picks, period by period, between the integer factor and the integer factor plus one. The long-run ratio is therefore the integer factor plus a 16-bit fraction over 65536. An optional extra half-step of 1/131072 acts as a dither term and can be switched off. The oscillator and the phase comparator sit outside the block.

The fraction and the dither choice are captured at the moment fractional operation is switched on. Writes made while it stays on change nothing. Two settings raise a configuration error flag: an integer factor of zero, which the block then treats as one, and integer factors of five, six or seven while fractional operation is on.

Two small state machines run the block. The mode machine has states MODE_INT and MODE_FRAC. It moves from MODE_INT to MODE_FRAC in the cycle the enable is seen high, and captures the fraction on that move. It moves back from MODE_FRAC to MODE_INT in the cycle the enable is seen low. The divide machine has states DIV_START and DIV_RUN. After reset it spends exactly one cycle in DIV_START, where it loads the first count. It then moves to DIV_RUN and stays there, reloading the counter at each terminal count.

Top module: `fracn_loop_divider`

## Requirements
- R1: `rst` is synchronous and active high. While it is high, and in the first cycle after it is released, `fb_pulse` is low. After reset the block is in integer mode with the accumulator at zero.
- R2: In integer mode with factor N ≥ 1, `fb_pulse` is high for one cycle every N cycles. The first pulse comes N cycles after the start cycle that follows reset release.
- R3: In fractional mode, each period lasts N or N+1 cycles. At each terminal count a 17-bit accumulator adds the increment 2·FRAC + d, where d is 1 unless dither is off. A carry out of bit 16 makes the next period N+1.
- R4: With `dither_off` high at capture time, the increment is 2·FRAC, so the long-run ratio is N + FRAC/65536.
- R5: `frac_word` and `dither_off` are captured in the cycle that `frac_en` is seen high in integer mode. Changes made to them while fractional mode stays on have no effect on the pulse timing.
- R6: `cfg_err` is high in any cycle where the mode is fractional and `int_factor` is 5, 6 or 7. In integer mode those values do not raise it.
- R7: When `frac_en` goes low, the mode returns to integer and the accumulator is cleared. Every period that starts afterwards is exactly N.
- R8: `int_factor` = 0 raises `cfg_err` in either mode, and the block divides as if the factor were 1.
- R9: `int_factor` is sampled at each terminal count, so a change takes effect from the next period.
- R10: Over any 2^17 consecutive fractional periods with a fixed setting, the total cycle count is exactly 2^17·N + increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| int_factor | input | 6 | Integer divide factor N |
| frac_word | input | 16 | Fraction numerator over 65536 |
| frac_en | input | 1 | Fractional operation enable |
| dither_off | input | 1 | Drops the 1/131072 dither term when high |
| fb_pulse | output | 1 | One-cycle pulse at the end of each output period |
| cfg_err | output | 1 | Illegal configuration flag |

## Verification
`fb_pulse` is a decode of the divide counter and mode register, so it is high in the cycle the counter sits at zero. For a period of length L, that cycle is L edges after the edge that loaded the counter. `cfg_err` follows `int_factor` in the same cycle and follows a mode change one edge later. A captured fraction first shapes the period that begins at the next terminal count. The bench reference model advances one step per rising edge, using the inputs that edge will see, and compares both outputs at the following falling edge. Every expected value is therefore read in the cycle its register chain makes it valid. The long-run test counts cycles between two pulses 2^17 periods apart.

// File: rtl/fnd_pkg.sv
package fnd_pkg;

    // Mode state machine: integer division or fractional synthesis
    typedef enum logic [0:0] {
        MODE_INT  = 1'b0,
        MODE_FRAC = 1'b1
    } mode_e;

    // Divide counter state machine
    typedef enum logic [0:0] {
        DIV_START = 1'b0,
        DIV_RUN   = 1'b1
    } div_state_e;

endpackage

// File: rtl/fnd_cfg.sv
module fnd_cfg
    import fnd_pkg::*;
#(
    parameter int unsigned INT_W  = 6,
    parameter int unsigned FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frac_en,
    input  logic [FRAC_W-1:0] frac_word,
    input  logic              dither_off,
    input  logic [INT_W-1:0]  int_factor,
    output logic              frac_mode,
    output logic [FRAC_W-1:0] frac_lat,
    output logic              dith_lat,
    output logic [INT_W-1:0]  n_eff,
    output logic              cfg_err
);

    mode_e             mode_q;
    mode_e             mode_d;
    logic [FRAC_W-1:0] frac_q;
    logic              dith_q;
    logic              capture;
    logic              zero_n;
    logic              forbidden_n;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_INT;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Next-state logic
    always_comb begin
        mode_d  = mode_q;
        capture = 1'b0;
        unique case (mode_q)
            MODE_INT: begin
                if (frac_en) begin
                    mode_d  = MODE_FRAC;
                    capture = 1'b1;
                end
            end
            MODE_FRAC: begin
                if (!frac_en) begin
                    mode_d = MODE_INT;
                end
            end
            default: mode_d = MODE_INT;
        endcase
    end

    // Fraction and dither capture on entry to fractional mode
    always_ff @(posedge clk) begin
        if (rst) begin
            frac_q <= '0;
            dith_q <= 1'b0;
        end else if (capture) begin
            frac_q <= frac_word;
            dith_q <= ~dither_off;
        end
    end

    // Outputs
    always_comb begin
        zero_n      = (int_factor == '0);
        forbidden_n = (int_factor == INT_W'(5)) ||
                      (int_factor == INT_W'(6)) ||
                      (int_factor == INT_W'(7));
        frac_mode   = (mode_q == MODE_FRAC);
        frac_lat    = frac_q;
        dith_lat    = dith_q;
        n_eff       = zero_n ? INT_W'(1) : int_factor;
        cfg_err     = zero_n || (frac_mode && forbidden_n);
    end

endmodule

// File: rtl/fnd_accum.sv
module fnd_accum #(
    parameter int unsigned FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac_lat,
    input  logic              dith_lat,
    output logic              carry,
    output logic [FRAC_W:0]   acc_value
);

    localparam int unsigned ACC_W = FRAC_W + 1;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] incr;
    logic [ACC_W:0]   sum;

    // The fraction fills the upper bits, the dither bit is the half-step LSB
    assign incr = {frac_lat, dith_lat};
    assign sum  = {1'b0, acc_q} + {1'b0, incr};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= sum[ACC_W-1:0];
        end
    end

    assign carry     = sum[ACC_W];
    assign acc_value = acc_q;

endmodule

// File: rtl/fnd_counter.sv
module fnd_counter
    import fnd_pkg::*;
#(
    parameter int unsigned INT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INT_W-1:0] base_div,
    input  logic             extra,
    output logic             pulse
);

    localparam int unsigned DIV_W = INT_W + 1;

    div_state_e       st_q;
    div_state_e       st_d;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] cnt_d;
    logic [DIV_W-1:0] base_ext;

    assign base_ext = {1'b0, base_div};

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= DIV_START;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Next-state and count logic
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            DIV_START: begin
                st_d  = DIV_RUN;
                cnt_d = base_ext - DIV_W'(1);
            end
            DIV_RUN: begin
                if (cnt_q == '0) begin
                    cnt_d = base_ext + DIV_W'(extra) - DIV_W'(1);
                end else begin
                    cnt_d = cnt_q - DIV_W'(1);
                end
            end
            default: st_d = DIV_START;
        endcase
    end

    // Outputs
    always_comb begin
        pulse = (st_q == DIV_RUN) && (cnt_q == '0);
    end

endmodule

// File: rtl/fracn_loop_divider.sv
module fracn_loop_divider #(
    parameter int unsigned INT_W  = 6,
    parameter int unsigned FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [INT_W-1:0]  int_factor,
    input  logic [FRAC_W-1:0] frac_word,
    input  logic              frac_en,
    input  logic              dither_off,
    output logic              fb_pulse,
    output logic              cfg_err
);

    logic              frac_mode;
    logic [FRAC_W-1:0] frac_lat;
    logic              dith_lat;
    logic [INT_W-1:0]  n_eff;
    logic              carry;
    logic [FRAC_W:0]   acc_value;
    logic              pulse;
    logic              extra;

    fnd_cfg #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .frac_en    (frac_en),
        .frac_word  (frac_word),
        .dither_off (dither_off),
        .int_factor (int_factor),
        .frac_mode  (frac_mode),
        .frac_lat   (frac_lat),
        .dith_lat   (dith_lat),
        .n_eff      (n_eff),
        .cfg_err    (cfg_err)
    );

    fnd_accum #(
        .FRAC_W (FRAC_W)
    ) u_accum (
        .clk       (clk),
        .rst       (rst),
        .clear     (~frac_mode),
        .step      (pulse & frac_mode),
        .frac_lat  (frac_lat),
        .dith_lat  (dith_lat),
        .carry     (carry),
        .acc_value (acc_value)
    );

    assign extra = frac_mode & carry;

    fnd_counter #(
        .INT_W (INT_W)
    ) u_counter (
        .clk      (clk),
        .rst      (rst),
        .base_div (n_eff),
        .extra    (extra),
        .pulse    (pulse)
    );

    assign fb_pulse = pulse;

endmodule

// File: rtl/fnd_checker.sv
module fnd_checker #(
    parameter int unsigned INT_W  = 6,
    parameter int unsigned FRAC_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              fb_pulse,
    input logic              cfg_err,
    input logic [INT_W-1:0]  int_factor,
    input logic              frac_mode,
    input logic [FRAC_W-1:0] frac_lat,
    input logic [FRAC_W:0]   acc_value
);

    localparam int unsigned GAP_W   = INT_W + 2;
    localparam int unsigned MAX_GAP = 1 << INT_W;

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    // Cycles since the previous pulse, saturating
    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (fb_pulse) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    assert_quiet_after_reset_R1: assert property (@(posedge clk)
        rst |=> !fb_pulse);

    assert_period_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (seen_q && fb_pulse) |-> (32'(gap_q) < MAX_GAP));

    assert_frac_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (frac_mode && $past(frac_mode)) |-> $stable(frac_lat));

    assert_forbidden_flag_R6: assert property (@(posedge clk) disable iff (rst)
        (frac_mode && (int_factor >= INT_W'(5)) && (int_factor <= INT_W'(7))) |-> cfg_err);

    assert_accum_idle_R7: assert property (@(posedge clk) disable iff (rst)
        !frac_mode |=> (acc_value == '0));

    assert_zero_factor_R8: assert property (@(posedge clk) disable iff (rst)
        (int_factor == '0) |-> cfg_err);

endmodule

bind fracn_loop_divider fnd_checker #(
    .INT_W  (INT_W),
    .FRAC_W (FRAC_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fb_pulse   (fb_pulse),
    .cfg_err    (cfg_err),
    .int_factor (int_factor),
    .frac_mode  (frac_mode),
    .frac_lat   (frac_lat),
    .acc_value  (acc_value)
);

// File: tb/tb_fracn_loop_divider.sv
`timescale 1ns/1ps
module tb_fracn_loop_divider;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  int_factor = 6'd8;
    logic [15:0] frac_word = 16'd0;
    logic        frac_en = 1'b0;
    logic        dither_off = 1'b0;
    logic        fb_pulse;
    logic        cfg_err;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_req = "R1";
    longint cyc = 0;

    // Reference model state
    bit     m_frac = 1'b0;
    bit     m_started = 1'b0;
    int     m_rem = 0;
    longint m_tot = 0;
    int     m_lat = 0;
    int     m_dith = 0;

    always #2.5 clk = ~clk;

    fracn_loop_divider dut (
        .clk        (clk),
        .rst        (rst),
        .int_factor (int_factor),
        .frac_word  (frac_word),
        .frac_en    (frac_en),
        .dither_off (dither_off),
        .fb_pulse   (fb_pulse),
        .cfg_err    (cfg_err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit bad_int(input int n);
        return (n == 5) || (n == 6) || (n == 7);
    endfunction

    // Advance the model across the next rising edge, then compare at the falling edge
    task automatic tick();
        int     n;
        int     len;
        longint old;
        longint incr;
        n    = (int_factor == 0) ? 1 : int'(int_factor);
        incr = 2 * longint'(m_lat) + longint'(m_dith);
        if (rst) begin
            m_frac    = 1'b0;
            m_started = 1'b0;
            m_rem     = 0;
            m_tot     = 0;
        end else begin
            if (!m_started) begin
                m_started = 1'b1;
                m_rem     = n - 1;
            end else if (m_rem == 0) begin
                len = n;
                if (m_frac) begin
                    old   = m_tot;
                    m_tot = m_tot + incr;
                    len   = n + int'(m_tot / 131072 - old / 131072);
                end
                m_rem = len - 1;
            end else begin
                m_rem--;
            end
            if (!m_frac) m_tot = 0;
            if (!m_frac && frac_en) begin
                m_frac = 1'b1;
                m_lat  = int'(frac_word);
                m_dith = dither_off ? 0 : 1;
            end else if (m_frac && !frac_en) begin
                m_frac = 1'b0;
            end
        end
        @(negedge clk);
        cyc++;
        begin
            bit exp_p;
            bit exp_e;
            exp_p = m_started && (m_rem == 0);
            exp_e = (int_factor == 0) || (m_frac && bad_int(int'(int_factor)));
            chk(fb_pulse == exp_p, {cur_req, " pulse"}, fb_pulse, exp_p);
            chk(cfg_err == exp_e, {cur_req, " cfg_err"}, cfg_err, exp_e);
        end
    endtask

    task automatic run(input int k);
        for (int i = 0; i < k; i++) tick();
    endtask

    initial begin
        longint t0;
        longint t1;
        int     pcount;
        @(negedge clk);
        // R1: reset holds the pulse low
        cur_req = "R1";
        run(4);
        chk(fb_pulse == 1'b0, "R1 pulse low in reset", fb_pulse, 0);
        chk(cfg_err == 1'b0, "R1 no error in reset", cfg_err, 0);
        rst = 1'b0;
        tick();
        chk(fb_pulse == 1'b0, "R1 start cycle quiet", fb_pulse, 0);
        // R2: integer division
        cur_req = "R2";
        run(40);
        // R9: factor change takes effect from next period
        cur_req = "R9";
        int_factor = 6'd3;
        run(20);
        int_factor = 6'd1;
        run(10);
        cur_req = "R6";
        int_factor = 6'd5;
        run(20);
        chk(cfg_err == 1'b0, "R6 no error for 5 in integer mode", cfg_err, 0);
        // R8: zero factor
        cur_req = "R8";
        int_factor = 6'd0;
        run(10);
        chk(cfg_err == 1'b1, "R8 zero factor flagged", cfg_err, 1);
        // R4: dither off, increment exactly 65536
        cur_req = "R4";
        int_factor = 6'd10;
        frac_word = 16'h8000;
        dither_off = 1'b1;
        frac_en = 1'b1;
        run(200);
        // R5: writes while enabled are ignored
        cur_req = "R5";
        frac_word = 16'h0001;
        dither_off = 1'b0;
        run(200);
        // R6: forbidden factor in fractional mode
        cur_req = "R6";
        int_factor = 6'd6;
        run(50);
        chk(cfg_err == 1'b1, "R6 factor 6 flagged in fractional mode", cfg_err, 1);
        // R7: leaving fractional mode
        cur_req = "R7";
        int_factor = 6'd12;
        frac_en = 1'b0;
        run(60);
        // R3: dithered fractional division
        cur_req = "R3";
        int_factor = 6'd9;
        frac_word = 16'h1234;
        frac_en = 1'b1;
        run(2000);
        frac_en = 1'b0;
        run(5);
        // R10: long-run exact average
        cur_req = "R10";
        int_factor = 6'd1;
        frac_word = 16'h0800;
        dither_off = 1'b0;
        frac_en = 1'b1;
        run(3);
        while (!fb_pulse) tick();
        t0 = cyc;
        pcount = 0;
        while (pcount < 131072) begin
            tick();
            if (fb_pulse) pcount++;
        end
        t1 = cyc;
        chk((t1 - t0) == 64'd135169, "R10 cycles over 2^17 periods", t1 - t0, 135169);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule